// File: doc/BRIEF.md
# Sixteen-Point Number Theoretic Transform Engine

This block computes a forward 16-point number theoretic transform over the prime field p = 2^64 − 2^32 + 1. The root of unity is 2^12. It treats the sixteen points as a 4×4 grid. It first runs four 4-point transforms down the columns. It then scales the intermediate grid by twiddle factors. Last, it runs four 4-point transforms along the rows. A single 4-point kernel is reused for all eight passes. Because every twiddle factor is a power of two, each twiddle scaling is a shift followed by modular folding, and no general multiplier is needed.

A caller raises `start` while the engine is idle. It then supplies sixteen field elements in time order over a valid/ready handshake. When the transform finishes, the engine streams the sixteen results in natural frequency order, one per cycle, and marks the last result with `done`. In a large-integer multiplier built on this block, each operand is split into 24-bit digits that fill the lower eight points. The upper eight points stay zero, leaving room for the digits of the product. Sixteen points therefore cover operands of up to 192 bits.

Top module: `ntt16_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready`, `out_valid` and `done` are all low.
- R2: If `start` is high in an idle cycle, `in_ready` is high from the next cycle. It stays high until exactly sixteen beats with `in_valid` high have been accepted, and drops in the cycle after the sixteenth. `in_ready` and `out_valid` are never high together.
- R3: An input word at or above p is taken as the word minus p. For example, 2^64 − 1 counts as 2^32 − 2.
- R4: Result k, for k = 0 to 15, equals the sum over n of x[n]·(2^12)^(n·k) mod p, where x[n] is the n-th accepted input. The results appear in order k = 0, 1, …, 15 on sixteen consecutive cycles with `out_valid` high.
- R5: `done` is high for exactly one cycle, the cycle that carries result 15. `out_valid` is low in the cycle after it.
- R6: `start` has no effect unless the engine is idle. After a transform finishes, the engine stays idle with `in_ready` low until a new `start`.
- R7: `in_valid` and `in_data` are ignored outside the load phase. A cycle with `in_valid` low during the load phase accepts nothing and loses nothing.
- R8: Every word presented with `out_valid` high is below p.
- R9: The first result appears exactly 8 + 16/TWID_LANES cycles after the clock edge that accepts the sixteenth input. With the default single twiddle lane, this is 24 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new transform; honoured only when idle |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Engine is in its load phase and accepts a word |
| in_data | input | DATA_W | Input field element, time index order |
| out_valid | output | 1 | Result word present |
| out_data | output | DATA_W | Result field element, natural frequency order |
| done | output | 1 | Marks the final result of a transform |

## Verification
The bound checker watches the handshake framing on every cycle:
- the exclusion between `in_ready` and `out_valid`;
- the sixteen-beat length of the load window;
- the unbroken sixteen-cycle output burst with `done` on its last cycle;
- the range of every result;
- the rule that the load window opens only after `start` in an idle cycle.

The arithmetic is covered only by the bench scenarios. These compare each result against a direct quadratic transform computed with wide modular arithmetic. Input patterns include impulses, constant vectors, zero-padded 24-bit digits, non-canonical words and full 64-bit values. The same holds for the fixed latency and for inputs ignored while the engine is busy. The bench injects stray `start` and `in_valid` activity during computation and output, and stalls during loading.

// File: rtl/ntt16_pkg.sv
package ntt16_pkg;

   localparam logic [63:0] FIELD_P = 64'hFFFF_FFFF_0000_0001;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LOAD,
      PH_COL,
      PH_TWID,
      PH_ROW,
      PH_OUT
   } phase_t;

   // sum of two canonical elements
   function automatic logic [63:0] fp_add(input logic [63:0] a, input logic [63:0] b);
      logic [64:0] s;
      s = {1'b0, a} + {1'b0, b};
      if (s >= {1'b0, FIELD_P}) s = s - {1'b0, FIELD_P};
      return s[63:0];
   endfunction

   // difference of two canonical elements; wraparound keeps a-b+p exact
   function automatic logic [63:0] fp_sub(input logic [63:0] a, input logic [63:0] b);
      logic [63:0] d;
      if (a >= b) d = a - b;
      else        d = a - b + FIELD_P;
      return d;
   endfunction

   // bring a raw 64-bit word into [0, p)
   function automatic logic [63:0] fp_canon(input logic [63:0] x);
      return (x >= FIELD_P) ? x - FIELD_P : x;
   endfunction

   // reduce a non-negative value below 2^68 using 2^64 = 2^32 - 1 (mod p)
   function automatic logic [63:0] fp_fold68(input logic [67:0] t);
      logic [65:0] u;
      u = {2'b0, t[63:0]} + ({62'b0, t[67:64]} << 32) - {62'b0, t[67:64]};
      if (u >= {2'b0, FIELD_P}) u = u - {2'b0, FIELD_P};
      return u[63:0];
   endfunction

endpackage

// File: rtl/ntt16_shiftmod.sv
// y = x * 2^sh mod p, for canonical x and sh in [0, 192)
module ntt16_shiftmod
   import ntt16_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int SH_W   = 8
) (
   input  logic [DATA_W-1:0] x,
   input  logic [SH_W-1:0]   sh,
   output logic [DATA_W-1:0] y
);

   localparam int WIDE_W = DATA_W + 96;

   if (DATA_W != 64) begin : g_bad_width
      $error("ntt16_shiftmod supports only a 64-bit field");
   end
   if (SH_W < 8) begin : g_bad_shw
      $error("ntt16_shiftmod needs at least 8 shift bits");
   end

   logic              negate;
   logic [6:0]        amt;
   logic [WIDE_W-1:0] wide;
   logic [67:0]       pos_part;
   logic [67:0]       neg_part;
   logic [67:0]       diff;
   logic [63:0]       folded;

   always_comb begin
      // 2^96 = -1 (mod p): fold large shifts into a negation
      negate   = (sh >= SH_W'(96));
      amt      = negate ? 7'(sh - SH_W'(96)) : 7'(sh);
      wide     = {96'b0, x} << amt;
      // chunks of 32: d + c*2^32 + b*(2^32-1) - a - e*2^32, offset by 2p
      pos_part = 68'(wide[31:0])
               + (68'({1'b0, wide[63:32]} + {1'b0, wide[95:64]}) << 32)
               + {3'b0, FIELD_P, 1'b0};
      neg_part = 68'(wide[95:64]) + 68'(wide[127:96]) + (68'(wide[159:128]) << 32);
      diff     = pos_part - neg_part;
      folded   = fp_fold68(diff);
      y        = (negate && folded != 64'd0) ? FIELD_P - folded : folded;
   end

endmodule

// File: rtl/ntt16_kernel4.sv
// 4-point forward transform with root 2^48 (its square is -1 mod p)
module ntt16_kernel4
   import ntt16_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a0,
   input  logic [DATA_W-1:0] a1,
   input  logic [DATA_W-1:0] a2,
   input  logic [DATA_W-1:0] a3,
   output logic [DATA_W-1:0] q0,
   output logic [DATA_W-1:0] q1,
   output logic [DATA_W-1:0] q2,
   output logic [DATA_W-1:0] q3
);

   localparam logic [7:0] QUARTER_SH = 8'd48;

   logic [DATA_W-1:0] even_s, odd_s, even_d, odd_d, odd_rot;

   assign even_s = fp_add(a0, a2);
   assign odd_s  = fp_add(a1, a3);
   assign even_d = fp_sub(a0, a2);
   assign odd_d  = fp_sub(a1, a3);

   ntt16_shiftmod #(.DATA_W(DATA_W), .SH_W(8)) u_rot (
      .x  (odd_d),
      .sh (QUARTER_SH),
      .y  (odd_rot)
   );

   assign q0 = fp_add(even_s, odd_s);
   assign q2 = fp_sub(even_s, odd_s);
   assign q1 = fp_add(even_d, odd_rot);
   assign q3 = fp_sub(even_d, odd_rot);

endmodule

// File: rtl/ntt16_ctrl.sv
// phase sequencer: idle, load, column passes, twiddle steps, row passes, output
module ntt16_ctrl
   import ntt16_pkg::*;
#(
   parameter int CNT_W     = 4,
   parameter int LOAD_LAST = 15,
   parameter int COL_LAST  = 3,
   parameter int TWID_LAST = 15,
   parameter int ROW_LAST  = 3,
   parameter int OUT_LAST  = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             in_valid,
   output phase_t           phase,
   output logic [CNT_W-1:0] cnt
);

   logic at_last;

   always_comb begin
      unique case (phase)
         PH_LOAD: at_last = (cnt == CNT_W'(LOAD_LAST));
         PH_COL:  at_last = (cnt == CNT_W'(COL_LAST));
         PH_TWID: at_last = (cnt == CNT_W'(TWID_LAST));
         PH_ROW:  at_last = (cnt == CNT_W'(ROW_LAST));
         PH_OUT:  at_last = (cnt == CNT_W'(OUT_LAST));
         default: at_last = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               cnt <= '0;
               if (start) phase <= PH_LOAD;
            end
            PH_LOAD: begin
               if (in_valid) begin
                  cnt <= at_last ? '0 : cnt + CNT_W'(1);
                  if (at_last) phase <= PH_COL;
               end
            end
            PH_COL: begin
               cnt <= at_last ? '0 : cnt + CNT_W'(1);
               if (at_last) phase <= PH_TWID;
            end
            PH_TWID: begin
               cnt <= at_last ? '0 : cnt + CNT_W'(1);
               if (at_last) phase <= PH_ROW;
            end
            PH_ROW: begin
               cnt <= at_last ? '0 : cnt + CNT_W'(1);
               if (at_last) phase <= PH_OUT;
            end
            PH_OUT: begin
               cnt <= at_last ? '0 : cnt + CNT_W'(1);
               if (at_last) phase <= PH_IDLE;
            end
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/ntt16_engine.sv
module ntt16_engine
   import ntt16_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int RADIX      = 4,
   parameter int ROOT_LOG2  = 12,
   parameter int TWID_LANES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              done
);

   localparam int POINTS   = RADIX * RADIX;
   localparam int IDX_W    = $clog2(POINTS);
   localparam int RW       = $clog2(RADIX);
   localparam int TW_STEPS = POINTS / TWID_LANES;
   localparam int SH_W     = 8;

   if (DATA_W != 64) begin : g_chk_width
      $error("ntt16_engine: DATA_W must be 64");
   end
   if (RADIX != 4) begin : g_chk_radix
      $error("ntt16_engine: RADIX must be 4");
   end
   if (ROOT_LOG2 != 12) begin : g_chk_root
      $error("ntt16_engine: ROOT_LOG2 must be 12");
   end
   if (TWID_LANES < 1 || (POINTS % TWID_LANES) != 0) begin : g_chk_lanes
      $error("ntt16_engine: TWID_LANES must divide the point count");
   end

   phase_t            phase;
   logic [IDX_W-1:0]  cnt;
   logic [DATA_W-1:0] pts [POINTS];

   ntt16_ctrl #(
      .CNT_W     (IDX_W),
      .LOAD_LAST (POINTS - 1),
      .COL_LAST  (RADIX - 1),
      .TWID_LAST (TW_STEPS - 1),
      .ROW_LAST  (RADIX - 1),
      .OUT_LAST  (POINTS - 1)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .in_valid (in_valid),
      .phase    (phase),
      .cnt      (cnt)
   );

   // kernel operand selection: column pass walks a stride of RADIX,
   // row pass walks consecutive points
   logic [IDX_W-1:0]  kidx [RADIX];
   logic [DATA_W-1:0] kin  [RADIX];
   logic [DATA_W-1:0] kout [RADIX];

   always_comb begin
      for (int j = 0; j < RADIX; j++) begin
         if (phase == PH_COL) kidx[j] = {RW'(j), cnt[RW-1:0]};
         else                 kidx[j] = {cnt[RW-1:0], RW'(j)};
         kin[j] = pts[kidx[j]];
      end
   end

   ntt16_kernel4 #(.DATA_W(DATA_W)) u_kernel (
      .a0 (kin[0]),
      .a1 (kin[1]),
      .a2 (kin[2]),
      .a3 (kin[3]),
      .q0 (kout[0]),
      .q1 (kout[1]),
      .q2 (kout[2]),
      .q3 (kout[3])
   );

   // twiddle lanes: point at column n1, row k2 is scaled by 2^(12*n1*k2)
   logic [IDX_W-1:0]  tw_idx [TWID_LANES];
   logic [DATA_W-1:0] tw_res [TWID_LANES];

   for (genvar l = 0; l < TWID_LANES; l++) begin : g_lane
      logic [SH_W-1:0] amt;
      assign tw_idx[l] = IDX_W'(int'(cnt) * TWID_LANES + l);
      assign amt       = SH_W'(ROOT_LOG2 * int'(tw_idx[l][RW-1:0])
                                         * int'(tw_idx[l][IDX_W-1:RW]));
      ntt16_shiftmod #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
         .x  (pts[tw_idx[l]]),
         .sh (amt),
         .y  (tw_res[l])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < POINTS; i++) pts[i] <= '0;
      end else begin
         unique case (phase)
            PH_LOAD: if (in_valid) pts[cnt] <= fp_canon(in_data);
            PH_COL, PH_ROW: begin
               for (int j = 0; j < RADIX; j++) pts[kidx[j]] <= kout[j];
            end
            PH_TWID: begin
               for (int l = 0; l < TWID_LANES; l++) pts[tw_idx[l]] <= tw_res[l];
            end
            default: ;
         endcase
      end
   end

   // result k = kc + RADIX*kr sits at row kc, position kr: transpose on readout
   assign in_ready  = (phase == PH_LOAD);
   assign out_valid = (phase == PH_OUT);
   assign out_data  = pts[{cnt[RW-1:0], cnt[IDX_W-1:RW]}];
   assign done      = out_valid && (cnt == IDX_W'(POINTS - 1));

endmodule

// File: rtl/ntt16_engine_chk.sv
module ntt16_engine_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              done
);

   localparam logic [DATA_W-1:0] PRIME = DATA_W'(64'hFFFF_FFFF_0000_0001);

   logic [4:0] beats;
   logic [4:0] ocnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beats <= '0;
         ocnt  <= '0;
      end else begin
         if (!in_ready)     beats <= '0;
         else if (in_valid) beats <= beats + 5'd1;
         if (out_valid) ocnt <= ocnt + 5'd1;
         else           ocnt <= '0;
      end
   end

   // R2
   ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   // R2
   load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !(in_valid && beats == 5'd15)) |=> in_ready);

   // R2
   load_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid && beats == 5'd15) |=> !in_ready);

   // R4
   out_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ocnt != 5'd15) |=> out_valid);

   // R5
   done_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (done == (ocnt == 5'd15)));

   // R5
   done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> out_valid);

   // R5
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !out_valid);

   // R6
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> ($past(start) && !$past(out_valid)));

   // R8
   out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data < PRIME));

endmodule

bind ntt16_engine ntt16_engine_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_ntt16_engine.sv
`timescale 1ns/1ps
module sim_ntt16_engine;

   localparam logic [63:0] PM = 64'hFFFF_FFFF_0000_0001;
   localparam int EXP_LAT = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_data = '0;
   logic        out_valid;
   logic [63:0] out_data;
   logic        done;

   int n_chk = 0;
   int n_fail = 0;

   logic [63:0] vec [16];
   logic [63:0] expv [16];
   logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

   always #5 clk = ~clk;

   ntt16_engine u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .done      (done)
   );

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic logic [63:0] mmul(input logic [63:0] a, input logic [63:0] b);
      logic [127:0] t;
      t = (128'(a) * 128'(b)) % 128'(PM);
      return t[63:0];
   endfunction

   function automatic logic [63:0] madd(input logic [63:0] a, input logic [63:0] b);
      logic [64:0] t;
      t = (65'(a) + 65'(b)) % 65'(PM);
      return t[63:0];
   endfunction

   function automatic logic [63:0] next_rand();
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      return seed ^ (seed >> 29);
   endfunction

   // direct quadratic transform with root 2^12
   task automatic compute_expected();
      logic [63:0] pw [16];
      pw[0] = 64'd1;
      for (int i = 1; i < 16; i++) pw[i] = mmul(pw[i-1], 64'd4096);
      for (int k = 0; k < 16; k++) begin
         logic [63:0] acc;
         acc = 64'd0;
         for (int n = 0; n < 16; n++)
            acc = madd(acc, mmul(vec[n] % PM, pw[(n * k) % 16]));
         expv[k] = acc;
      end
   endtask

   task automatic run_vector(input string name, input bit gaps, input bit chaos);
      int lat;
      compute_expected();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(in_ready === 1'b1, $sformatf("R2 %s load window open", name), 64'(in_ready), 64'd1);
      for (int n = 0; n < 16; n++) begin
         if (gaps && (n % 3) == 1) begin
            in_valid = 1'b0;
            in_data  = 64'hDEAD_BEEF_DEAD_BEEF;
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_data  = vec[n];
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_data  = '0;
      check(in_ready === 1'b0, $sformatf("R2 %s load window closed", name), 64'(in_ready), 64'd0);
      lat = 0;
      while (!out_valid && lat < 200) begin
         if (chaos) begin
            // R6 R7: stray start and input activity while busy
            start    = 1'b1;
            in_valid = 1'b1;
            in_data  = ~vec[lat % 16];
         end
         @(negedge clk);
         lat++;
      end
      check(lat == EXP_LAT, $sformatf("R9 %s latency", name), 64'(lat), 64'(EXP_LAT));
      for (int k = 0; k < 16; k++) begin
         check(out_valid === 1'b1, $sformatf("R4 %s valid k=%0d", name, k), 64'(out_valid), 64'd1);
         check(out_data === expv[k], $sformatf("R4 %s result k=%0d", name, k), out_data, expv[k]);
         check(out_data < PM, $sformatf("R8 %s range k=%0d", name, k), out_data, PM);
         check(done === (k == 15), $sformatf("R5 %s done k=%0d", name, k), 64'(done), 64'(k == 15));
         if (chaos && k < 14) begin
            start    = 1'b1;
            in_valid = 1'b1;
            in_data  = 64'(k);
         end else begin
            start    = 1'b0;
            in_valid = 1'b0;
         end
         @(negedge clk);
      end
      for (int c = 0; c < 3; c++) begin
         check(!out_valid && !in_ready && !done, $sformatf("R6 %s idle after done c=%0d", name, c),
               {61'b0, out_valid, in_ready, done}, 64'd0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!in_ready && !out_valid && !done, "R1 during reset",
            {61'b0, in_ready, out_valid, done}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!in_ready && !out_valid && !done, "R1 after reset",
            {61'b0, in_ready, out_valid, done}, 64'd0);
      // R7: input activity while idle opens nothing
      in_valid = 1'b1;
      in_data  = 64'h5555;
      repeat (3) @(negedge clk);
      check(in_ready === 1'b0, "R7 idle ignores in_valid", 64'(in_ready), 64'd0);
      in_valid = 1'b0;

      for (int n = 0; n < 16; n++) vec[n] = (n == 0) ? 64'd1 : 64'd0;
      run_vector("impulse0", 1'b0, 1'b0);

      for (int n = 0; n < 16; n++) vec[n] = (n == 1) ? 64'd1 : 64'd0;
      run_vector("impulse1", 1'b0, 1'b0);

      for (int n = 0; n < 16; n++) vec[n] = (n == 15) ? 64'd7 : 64'd0;
      run_vector("impulse15", 1'b0, 1'b1);

      for (int n = 0; n < 16; n++) vec[n] = 64'd1;
      run_vector("ones", 1'b1, 1'b0);

      for (int n = 0; n < 16; n++) vec[n] = (n < 8) ? (next_rand() & 64'hFF_FFFF) : 64'd0;
      run_vector("digits24", 1'b1, 1'b1);

      for (int n = 0; n < 16; n++) vec[n] = PM - 64'd1;
      run_vector("pminus1", 1'b0, 1'b0);

      // R3: non-canonical inputs at and above p
      for (int n = 0; n < 16; n++)
         vec[n] = (n % 2 == 0) ? PM + 64'(n) : ((n % 4 == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'(n));
      run_vector("R3_noncanon", 1'b0, 1'b1);

      for (int n = 0; n < 16; n++) vec[n] = next_rand();
      run_vector("full64", 1'b1, 1'b1);

      for (int v = 0; v < 3; v++) begin
         for (int n = 0; n < 16; n++) vec[n] = next_rand() % PM;
         run_vector($sformatf("rand%0d", v), v[0], v[1]);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule